// File: doc/BRIEF.md
# Adaptive Provider Selector for Tagged Indirect-Target Tables

This block decides which of several tagged target tables supplies the predicted target of an indirect branch. The tables are looked up with global histories of increasing length. Table 0 uses the shortest history and table N-1 the longest. Each table reports whether its tag matched and, if so, the stored target. Every table except table 0 also reports a one-bit defer flag from the matching entry. A matching entry whose defer flag is clear supplies the target. A matching entry whose defer flag is set hands the choice down to the next shorter table that also matched. The block drives the chosen target and table number, or a no-prediction indication, purely combinationally.

At update time, the block takes the hit pattern and a per-table "this hit predicted correctly" vector, and produces write-enables that set defer flags. When the longest match was wrong but a shorter matching table was right, every matching entry longer than the nearest correct one is told to defer. Defer flags start cleared, so a freshly cleared predictor picks the longest match. The table SRAMs, hashing and allocation live outside this block.

Top module: `alt_provider_sel`

## Requirements
- R1: Table numbering is 0-based. Index 0 is the shortest history and index NT-1 the longest. Bit i of each per-table vector and target slice `lk_tgt[i*TW +: TW]` belong to table i. Bit i-1 of the defer and write-enable vectors belongs to table i. `pred_tbl` is the binary table index.
- R2: When every defer flag is clear, the longest matching table provides the target and table number, with `pred_valid` high.
- R3: A matching table with a clear defer flag provides the prediction when all longer matching tables have their defer flags set. A set flag passes the choice to the next shorter matching table, skipping tables without a match.
- R4: A table without a tag match is never the provider, and its defer flag and target have no effect on the outputs.
- R5: A match in table 0 always ends the chain, because table 0 has no defer flag.
- R6: With no match at all, or with every matching table deferring, `pred_valid` is 0, `pred_tgt` is 0 and `pred_tbl` is 0.
- R7: On update, if the longest matching table was wrong and at least one shorter matching table was correct, `alt_set_we` is high for exactly the matching tables longer than the longest correct shorter table.
- R8: `alt_set_we` is all zero when there is no match, when the longest match was correct, or when no shorter matching table was correct. Correctness bits of non-matching tables have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lk_hit | input | NT | Tag-match flag per table at lookup |
| lk_alt | input | NT-1 | Defer flag of the matching entry, tables 1..NT-1 |
| lk_tgt | input | NT*TW | Target per table, table i in bits i*TW +: TW |
| pred_valid | output | 1 | A provider was found |
| pred_tgt | output | TW | Chosen target, 0 when no provider |
| pred_tbl | output | $clog2(NT) | Chosen table index, 0 when no provider |
| up_hit | input | NT | Tag-match flag per table at update |
| up_ok | input | NT | Per-table correctness of the matching entry's target |
| alt_set_we | output | NT-1 | Set-enable for the defer flag, tables 1..NT-1 |

## Verification
Lookups are tried with the following patterns:
- No hit at all.
- A single hit in the longest table.
- Hits at both ends of the range.
- Sparse hits with gaps between them.
- Every table hitting.

For each pattern, the defer flags are varied: all clear, a set flag on the top hit only, flags chained down through several hits, and flags set everywhere. This separates three cases:
- a plain longest-match choice;
- a chain that skips non-matching tables;
- a chain that runs off the bottom.

Setting flags only on non-matching tables shows that they are ignored. Update patterns vary where the correct hits sit relative to the longest hit: nearest only, farthest only, both, none, and only on non-matching tables. These show the choice of the nearest correct table and the exact span of enables.

// File: rtl/aps_pkg.sv
package aps_pkg;
  localparam int unsigned APS_NT_DEF = 12;
  localparam int unsigned APS_TW_DEF = 32;

  // width of a table index for a given table count
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/aps_msb_find.sv
module aps_msb_find #(
  parameter int unsigned W  = 12,
  parameter int unsigned IW = 4
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    if (found) assert_found_set_R1: assert (vec[idx]);
    else       assert_none_set_R1: assert (vec == '0);
  end
endmodule

// File: rtl/aps_lookup.sv
module aps_lookup #(
  parameter int unsigned NT = 12,
  parameter int unsigned TW = 32,
  parameter int unsigned IW = 4
) (
  input  logic [NT-1:0]    hit,
  input  logic [NT-2:0]    alt,
  input  logic [NT*TW-1:0] tgt,
  output logic             valid,
  output logic [TW-1:0]    target,
  output logic [IW-1:0]    tbl
);
  logic [NT-1:0] stop_here;
  logic [IW-1:0] prov_idx, top_idx;
  logic          prov_found, top_found;
  logic          alt_all_clear;

  // a table ends the chain when it matched and does not defer
  assign stop_here[0] = hit[0];
  for (genvar i = 1; i < NT; i++) begin : g_stop
    assign stop_here[i] = hit[i] & ~alt[i-1];
  end

  aps_msb_find #(.W(NT), .IW(IW)) u_prov (
    .vec(stop_here), .idx(prov_idx), .found(prov_found));
  aps_msb_find #(.W(NT), .IW(IW)) u_top (
    .vec(hit), .idx(top_idx), .found(top_found));

  assign valid         = prov_found;
  assign tbl           = prov_found ? prov_idx : '0;
  assign target        = prov_found ? tgt[prov_idx*TW +: TW] : '0;
  assign alt_all_clear = (alt == '0);

  always_comb begin
    if (valid) begin
      assert_provider_matched_R4: assert (hit[tbl]);
      if (tbl != '0) assert_provider_not_deferring_R3: assert (!alt[tbl-1]);
      for (int i = 1; i < NT; i++) begin
        if (hit[i] && (IW'(i) > tbl)) assert_longer_hits_defer_R3: assert (alt[i-1]);
      end
    end else begin
      assert_no_pred_zero_R6: assert (target == '0 && tbl == '0);
      assert_no_pred_bottom_R5: assert (!hit[0]);
    end
    if (alt_all_clear && top_found) assert_longest_when_clear_R2: assert (valid && tbl == top_idx);
  end
endmodule

// File: rtl/aps_update.sv
module aps_update #(
  parameter int unsigned NT = 12,
  parameter int unsigned IW = 4
) (
  input  logic [NT-1:0] hit,
  input  logic [NT-1:0] ok,
  output logic [NT-2:0] set_we
);
  logic [IW-1:0] top_idx, near_idx;
  logic          top_found, near_found;
  logic [NT-1:0] below_top, good_below;
  logic          fire;

  aps_msb_find #(.W(NT), .IW(IW)) u_top (
    .vec(hit), .idx(top_idx), .found(top_found));

  for (genvar i = 0; i < NT; i++) begin : g_below
    assign below_top[i]  = top_found && (IW'(i) < top_idx);
    assign good_below[i] = hit[i] & ok[i] & below_top[i];
  end

  aps_msb_find #(.W(NT), .IW(IW)) u_near (
    .vec(good_below), .idx(near_idx), .found(near_found));

  assign fire = top_found & ~ok[top_idx] & near_found;

  for (genvar i = 1; i < NT; i++) begin : g_we
    assign set_we[i-1] = fire & hit[i] & (IW'(i) > near_idx);
  end

  always_comb begin
    for (int i = 1; i < NT; i++) begin
      if (set_we[i-1]) assert_we_only_on_hits_R8: assert (hit[i]);
    end
    if (set_we != '0) begin
      assert_we_needs_wrong_top_R8: assert (!ok[top_idx]);
      assert_we_covers_top_R7: assert (top_idx != '0 && set_we[top_idx-1]);
    end
    if (!top_found) assert_no_we_without_hit_R8: assert (set_we == '0);
  end
endmodule

// File: rtl/alt_provider_sel.sv
module alt_provider_sel #(
  parameter int unsigned NT = aps_pkg::APS_NT_DEF,
  parameter int unsigned TW = aps_pkg::APS_TW_DEF,
  localparam int unsigned IW = aps_pkg::idx_bits(NT)
) (
  input  logic [NT-1:0]    lk_hit,
  input  logic [NT-2:0]    lk_alt,
  input  logic [NT*TW-1:0] lk_tgt,
  output logic             pred_valid,
  output logic [TW-1:0]    pred_tgt,
  output logic [IW-1:0]    pred_tbl,
  input  logic [NT-1:0]    up_hit,
  input  logic [NT-1:0]    up_ok,
  output logic [NT-2:0]    alt_set_we
);
  aps_lookup #(.NT(NT), .TW(TW), .IW(IW)) u_lookup (
    .hit(lk_hit), .alt(lk_alt), .tgt(lk_tgt),
    .valid(pred_valid), .target(pred_tgt), .tbl(pred_tbl));

  aps_update #(.NT(NT), .IW(IW)) u_update (
    .hit(up_hit), .ok(up_ok), .set_we(alt_set_we));
endmodule

// File: tb/alt_provider_sel_tb.sv
module alt_provider_sel_tb;
  localparam int NT = 12;
  localparam int TW = 32;

  typedef struct packed {
    logic [11:0] hit;
    logic [10:0] alt;
    logic        v;
    logic [3:0]  tbl;
  } lk_vec_t;

  typedef struct packed {
    logic [11:0] hit;
    logic [11:0] ok;
    logic [10:0] we;
  } up_vec_t;

  localparam int NLK = 16;
  localparam lk_vec_t LKV [NLK] = '{
    '{12'h000, 11'h000, 1'b0, 4'd0},   // R6 nothing hits
    '{12'h800, 11'h000, 1'b1, 4'd11},  // R2 lone longest
    '{12'h801, 11'h000, 1'b1, 4'd11},  // R2 both ends
    '{12'h801, 11'h400, 1'b1, 4'd0},   // R3 defer skips to table 0
    '{12'h800, 11'h400, 1'b0, 4'd0},   // R6 deferred past all
    '{12'h0A4, 11'h040, 1'b1, 4'd5},   // R3 skip gap 7->5
    '{12'h0A4, 11'h050, 1'b1, 4'd2},   // R3 chain 7->5->2
    '{12'h0A4, 11'h052, 1'b0, 4'd0},   // R6 chain off bottom
    '{12'h0A4, 11'h7FF, 1'b0, 4'd0},   // R6 all defer
    '{12'h001, 11'h7FF, 1'b1, 4'd0},   // R5 table 0 stops
    '{12'h0A4, 11'h7EF, 1'b1, 4'd5},   // R4 non-hit flags ignored
    '{12'h000, 11'h7FF, 1'b0, 4'd0},   // R4 flags without hits
    '{12'hFFF, 11'h000, 1'b1, 4'd11},  // R2 all hit
    '{12'hFFF, 11'h3FF, 1'b1, 4'd11},  // R3 top clear
    '{12'hFFF, 11'h7FF, 1'b1, 4'd0},   // R5 all defer to table 0
    '{12'h014, 11'h7F5, 1'b1, 4'd4}    // R4 table 4 clear
  };

  localparam int NUP = 11;
  localparam up_vec_t UPV [NUP] = '{
    '{12'h000, 12'hFFF, 11'h000},  // R8 no hit
    '{12'h0A4, 12'h080, 11'h000},  // R8 longest correct
    '{12'h0A4, 12'h020, 11'h040},  // R7 nearest correct 5
    '{12'h0A4, 12'h004, 11'h050},  // R7 only 2 correct
    '{12'h0A4, 12'h024, 11'h040},  // R7 nearest wins
    '{12'h0A4, 12'h000, 11'h000},  // R8 none correct
    '{12'h0A4, 12'hF5B, 11'h000},  // R8 non-hit ok ignored
    '{12'h801, 12'h001, 11'h400},  // R7 ends
    '{12'hFFF, 12'h001, 11'h7FF},  // R7 full span
    '{12'h001, 12'h000, 11'h000},  // R8 single hit
    '{12'hFFF, 12'h7FF, 11'h400}   // R7 top only
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [NT-1:0]    lk_hit = '0, up_hit = '0, up_ok = '0;
  logic [NT-2:0]    lk_alt = '0;
  logic [NT*TW-1:0] lk_tgt;
  logic             pred_valid;
  logic [TW-1:0]    pred_tgt;
  logic [3:0]       pred_tbl;
  logic [NT-2:0]    alt_set_we;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  alt_provider_sel #(.NT(NT), .TW(TW)) u_dut (
    .lk_hit(lk_hit), .lk_alt(lk_alt), .lk_tgt(lk_tgt),
    .pred_valid(pred_valid), .pred_tgt(pred_tgt), .pred_tbl(pred_tbl),
    .up_hit(up_hit), .up_ok(up_ok), .alt_set_we(alt_set_we));

  function automatic logic [TW-1:0] tgt_of(input int t, input int seed);
    return 32'hA000_0000 + 32'(t) * 32'h0000_1111 + 32'(seed) * 32'h0010_0000;
  endfunction

  task automatic load_tgts(input int seed);
    for (int t = 0; t < NT; t++) lk_tgt[t*TW +: TW] = tgt_of(t, seed);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_lookup(input string req, input logic v, input logic [3:0] t, input int seed);
    chk({req, " valid"}, 32'(pred_valid), 32'(v));
    chk({req, " table"}, 32'(pred_tbl), 32'(t));
    chk({req, " target"}, pred_tgt, v ? tgt_of(int'(t), seed) : 32'h0);
  endtask

  initial begin
    load_tgts(0);
    @(negedge clk);
    #1;
    // cleared flags behave as longest match
    check_lookup("R6 cleared-no-hit", 1'b0, 4'd0, 0);
    lk_hit = 12'h0A4;
    @(negedge clk);
    #1;
    check_lookup("R2 cleared-longest", 1'b1, 4'd7, 0);

    for (int k = 0; k < NLK; k++) begin
      @(negedge clk);
      lk_hit = LKV[k].hit;
      lk_alt = LKV[k].alt;
      load_tgts(k + 1);
      #1;
      check_lookup($sformatf("R3/R4/R5/R6 lookup vector %0d", k), LKV[k].v, LKV[k].tbl, k + 1);
    end

    for (int k = 0; k < NUP; k++) begin
      @(negedge clk);
      up_hit = UPV[k].hit;
      up_ok  = UPV[k].ok;
      #1;
      chk($sformatf("R7/R8 update vector %0d", k), 32'(alt_set_we), 32'(UPV[k].we));
    end

    // R1 field positions: lone hit in each table, flags clear, target slice follows index
    lk_alt = '0;
    for (int t = 0; t < NT; t++) begin
      @(negedge clk);
      lk_hit = NT'(1) << t;
      load_tgts(40 + t);
      #1;
      check_lookup($sformatf("R1 single table %0d", t), 1'b1, 4'(t), 40 + t);
    end

    // R4 the target of a non-matching longer table does not leak
    @(negedge clk);
    lk_hit = 12'h010;
    lk_alt = 11'h000;
    load_tgts(60);
    lk_tgt[11*TW +: TW] = 32'hDEAD_BEEF;
    #1;
    check_lookup("R4 non-hit target ignored", 1'b1, 4'd4, 60);

    // R7 enable bit position: hit in table 1 (bit 0) and table 0
    @(negedge clk);
    up_hit = 12'h003;
    up_ok  = 12'h001;
    #1;
    chk("R7 we bit0 is table 1", 32'(alt_set_we), 32'h1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule